// File: doc/BRIEF.md
# Dense 12-bit Sample Packer for a Four-Lane Octet Link

This block sits between a single converter channel and the transport layer of a multi-lane serial link. It collects 12-bit samples arriving under a valid/ready handshake. Each group of 20 accepted samples becomes one frame. The frame is spread over four lanes, and every lane takes five consecutive samples. Inside a lane the five samples are packed with no padding between them. That gives 60 data bits, and four zero bits close the lane word. Each lane therefore carries 64 bits, or eight octets, per frame.

The lane words go out one octet per lane per clock, most significant octet first. The first octet of every frame carries a start-of-frame flag. A new frame is collected while the previous one is still being sent, so a stream of one sample per clock flows without stalls. Line coding, scrambling and alignment characters belong to later stages.

Top module: `dense_lane_packer`

## Requirements
- R1: The 20 samples accepted since reset or since the previous frame make up one frame. Lane l carries frame samples 5l to 5l+4, and lane l's octet appears on `out_octet[8l+7:8l]`.
- R2: A lane word is the lane's five samples joined most significant bit first with no gaps. Octet 0 is sample bits [11:4]. The next octet is the low nibble of that sample followed by bits [11:8] of the next sample. The octet after that is bits [7:0] of the next sample, and the pattern repeats for each pair.
- R3: Bits [3:0] of octet 7 of every lane are zero. Only the data nibble is carried in the upper half of that octet.
- R4: Each frame is sent as exactly 8 consecutive octets per lane. `out_valid` is high for those 8 cycles, with octet 0 first.
- R5: `out_sof` is high on octet 0 of each frame and low on every other cycle.
- R6: Octet 0 of a frame is presented in the cycle right after the clock edge that accepts the frame's 20th sample.
- R7: Cycles with `in_valid` low add no sample. No octet is sent before all 20 samples of a frame have been accepted, however long the gap is.
- R8: With one sample offered per clock, `in_ready` stays high and frames follow each other with no lost samples.
- R9: A synchronous reset drops a partly collected frame and clears `out_valid`. The next accepted sample becomes sample 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample will be taken at the next edge |
| in_sample | input | 12 | Converter sample |
| out_valid | output | 1 | Lane octets valid |
| out_sof | output | 1 | First octet of a frame |
| out_octet | output | 32 | One octet per lane, lane 0 in the low byte |

## Verification
The only latency is one cycle. Octet 0 of a frame is due in the cycle after the edge that takes sample 19, and each later octet follows one cycle after the one before it. The bench changes inputs just after a rising edge and samples outputs at the falling edge. When it sees a transfer of sample 19 at one falling edge, it expects the start flag at the next falling edge. It then checks octets 1 to 7 on the seven falling edges that follow. Gapped, stalled and reset scenarios are judged by the same per-edge rule, and a start flag seen at any other time counts as a failure.

// File: rtl/dense_pack_pkg.sv
package dense_pack_pkg;
  localparam int OCTET_W = 8;

  function automatic int octets_for(input int bits);
    return (bits + OCTET_W - 1) / OCTET_W;
  endfunction
endpackage

// File: rtl/dp_sample_collect.sv
module dp_sample_collect #(
  parameter int SAMPLE_W = 12,
  parameter int FRAME_S  = 20
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [SAMPLE_W-1:0]         in_sample,
  input  logic                        emit_free,
  output logic                        in_ready,
  output logic                        frame_load,
  output logic [FRAME_S*SAMPLE_W-1:0] frame_bus
);
  localparam int IDX_W = $clog2(FRAME_S);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_S - 1);

  logic [IDX_W-1:0]    idx;
  logic [SAMPLE_W-1:0] store [FRAME_S-1];
  logic                accept;

  assign in_ready   = (idx != LAST) || emit_free;
  assign accept     = in_valid && in_ready;
  assign frame_load = accept && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (accept)
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept && (idx != LAST))
      store[idx] <= in_sample;
  end

  // sample 0 occupies the most significant slot
  for (genvar i = 0; i < FRAME_S - 1; i++) begin : g_slot
    assign frame_bus[(FRAME_S-1-i)*SAMPLE_W +: SAMPLE_W] = store[i];
  end
  assign frame_bus[SAMPLE_W-1:0] = in_sample;
endmodule

// File: rtl/dp_lane_pack.sv
module dp_lane_pack #(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 4,
  parameter int SPL      = 5,
  parameter int WORD_W   = 64
) (
  input  logic [LANES*SPL*SAMPLE_W-1:0] frame_bus,
  output logic [LANES*WORD_W-1:0]       lane_words
);
  localparam int LANE_DATA  = SPL * SAMPLE_W;
  localparam int FRAME_BITS = LANES * LANE_DATA;
  localparam int PAD_W      = WORD_W - LANE_DATA;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (PAD_W > 0) begin : g_pad
      assign lane_words[l*WORD_W +: WORD_W] =
        {frame_bus[FRAME_BITS-1-l*LANE_DATA -: LANE_DATA], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign lane_words[l*WORD_W +: WORD_W] =
        frame_bus[FRAME_BITS-1-l*LANE_DATA -: LANE_DATA];
    end
  end
endmodule

// File: rtl/dp_octet_emit.sv
module dp_octet_emit #(
  parameter int LANES  = 4,
  parameter int WORD_W = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [LANES*WORD_W-1:0] lane_words,
  output logic                    emit_free,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic [LANES*8-1:0]      out_octet
);
  localparam int OCTETS = WORD_W / 8;
  localparam int CW     = (OCTETS > 1) ? $clog2(OCTETS) : 1;
  localparam logic [CW-1:0] LASTO = CW'(OCTETS - 1);

  logic [WORD_W-1:0] sh [LANES];
  logic [CW-1:0]     cnt;
  logic              busy;

  assign emit_free = !busy || (cnt == LASTO);
  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      out_sof <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      out_sof <= 1'b1;
    end else begin
      out_sof <= 1'b0;
      if (busy) begin
        if (cnt == LASTO) busy <= 1'b0;
        else              cnt  <= cnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sh
    always_ff @(posedge clk) begin
      if (load)
        sh[l] <= lane_words[l*WORD_W +: WORD_W];
      else if (busy)
        sh[l] <= {sh[l][WORD_W-9:0], 8'h00};
    end
    assign out_octet[l*8 +: 8] = sh[l][WORD_W-1 -: 8];
  end
endmodule

// File: rtl/dense_lane_packer.sv
module dense_lane_packer
  import dense_pack_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 4,
  parameter int SPL      = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [SAMPLE_W-1:0]      in_sample,
  output logic                     out_valid,
  output logic                     out_sof,
  output logic [LANES*OCTET_W-1:0] out_octet
);
  localparam int FRAME_S = LANES * SPL;
  localparam int WORD_W  = octets_for(SPL * SAMPLE_W) * OCTET_W;

  logic                        emit_free;
  logic                        frame_load;
  logic [FRAME_S*SAMPLE_W-1:0] frame_bus;
  logic [LANES*WORD_W-1:0]     lane_words;

  dp_sample_collect #(.SAMPLE_W(SAMPLE_W), .FRAME_S(FRAME_S)) collect_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .emit_free(emit_free), .in_ready(in_ready), .frame_load(frame_load),
    .frame_bus(frame_bus)
  );

  dp_lane_pack #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .SPL(SPL),
                 .WORD_W(WORD_W)) pack_i (
    .frame_bus(frame_bus), .lane_words(lane_words)
  );

  dp_octet_emit #(.LANES(LANES), .WORD_W(WORD_W)) emit_i (
    .clk(clk), .rst(rst), .load(frame_load), .lane_words(lane_words),
    .emit_free(emit_free), .out_valid(out_valid), .out_sof(out_sof),
    .out_octet(out_octet)
  );
endmodule

// File: rtl/dense_lane_packer_chk.sv
module dense_lane_packer_chk #(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 4,
  parameter int SPL      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_sof,
  input logic [LANES*8-1:0] out_octet
);
  localparam int FRAME_S = LANES * SPL;
  localparam int OCTETS  = (SPL * SAMPLE_W + 7) / 8;
  localparam int PAD_W   = OCTETS * 8 - SPL * SAMPLE_W;
  localparam int AW      = $clog2(FRAME_S);
  localparam int CW      = (OCTETS > 1) ? $clog2(OCTETS) : 1;
  localparam logic [AW-1:0] ALAST = AW'(FRAME_S - 1);
  localparam logic [CW-1:0] OLAST = CW'(OCTETS - 1);
  localparam logic [7:0] PMASK = 8'((1 << PAD_W) - 1);

  logic [AW-1:0] acc;
  logic [CW-1:0] pos, cur_pos;
  logic          last_xfer, pad_ok;

  assign last_xfer = in_valid && in_ready && (acc == ALAST);
  assign cur_pos   = out_sof ? '0 : pos + 1'b1;

  always_comb begin
    pad_ok = 1'b1;
    for (int l = 0; l < LANES; l++)
      if ((out_octet[l*8 +: 8] & PMASK) != 8'h00) pad_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (in_valid && in_ready) acc <= (acc == ALAST) ? '0 : acc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (out_valid) pos <= cur_pos;
  end

  // R6
  last_sof_chk: assert property (@(posedge clk) disable iff (rst)
    last_xfer |=> (out_sof && out_valid));
  // R6
  sof_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> $past(last_xfer));
  // R5
  sof_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  // R4
  run_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> ($past(out_valid) && (pos < OLAST)));
  // R4
  run_end_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (cur_pos == OLAST)) |=> (!out_valid || out_sof));
  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (cur_pos == OLAST)) |-> pad_ok);
  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sof));
endmodule

bind dense_lane_packer dense_lane_packer_chk #(
  .SAMPLE_W(SAMPLE_W), .LANES(LANES), .SPL(SPL)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sof(out_sof), .out_octet(out_octet)
);

// File: tb/dense_lane_packer_tb_top.sv
module dense_lane_packer_tb_top;
  localparam int NV = 6;
  // stimulus vectors: {first sample, increment, idle gap period}
  localparam logic [27:0] VEC [NV] = '{
    {12'hFFF, 12'h000, 4'd0},
    {12'h000, 12'h000, 4'd0},
    {12'h800, 12'h001, 4'd0},
    {12'hABC, 12'h111, 4'd3},
    {12'h123, 12'h7F5, 4'd1},
    {12'h5A5, 12'hA5A, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_sample = '0;
  logic        out_valid, out_sof;
  logic [31:0] out_octet;

  int total = 0, bad = 0;
  int nf = 0, mon_f = 0, mon_o = 0, acc_n = 0;
  bit pend = 1'b0, done = 1'b0;
  logic [11:0] cur_s [20];
  logic [63:0] exp_w [16][4];

  always #4 clk = ~clk;

  dense_lane_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_sof(out_sof),
    .out_octet(out_octet)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic prep(input logic [11:0] base, input logic [11:0] step);
    for (int i = 0; i < 20; i++) cur_s[i] = base + 12'(i) * step;
    for (int l = 0; l < 4; l++) begin
      logic [63:0] w = '0;
      for (int k = 0; k < 5; k++) w = {w[51:0], cur_s[5*l+k]};
      exp_w[nf][l] = w << 4;
    end
    nf++;
  endtask

  task automatic drive_one(input logic [11:0] s);
    in_valid  = 1'b1;
    in_sample = s;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_range(input int lo, input int hi, input int gap);
    for (int i = lo; i <= hi; i++) begin
      drive_one(cur_s[i]);
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(posedge clk); #1;
      end
    end
  endtask

  // monitor: outputs sampled on falling edges
  always @(negedge clk) begin
    if (rst) begin
      acc_n = 0; pend = 1'b0; mon_o = 0;
    end else begin
      int o, cf;
      if (pend) chk(out_valid && out_sof, "R6 sof one cycle after 20th sample",
                    {62'd0, out_valid, out_sof}, 64'h3);
      else if (out_sof) chk(1'b0, "R5 unexpected sof", 64'd1, 64'd0);
      if (out_valid) begin
        if (out_sof) begin
          chk(mon_o == 0 || mon_o == 8, "R4 previous frame length", 64'(mon_o), 64'd8);
          o = 0; cf = mon_f; mon_f++;
        end else begin
          o = mon_o; cf = mon_f - 1;
        end
        if (o > 7 || cf < 0) chk(1'b0, "R4 extra octet", 64'(o), 64'd7);
        else begin
          for (int l = 0; l < 4; l++)
            chk(out_octet[8*l +: 8] == exp_w[cf][l][63-8*o -: 8],
                $sformatf("R1 R2 frame %0d lane %0d octet %0d", cf, l, o),
                64'(out_octet[8*l +: 8]), 64'(exp_w[cf][l][63-8*o -: 8]));
          if (o == 7)
            for (int l = 0; l < 4; l++)
              chk(out_octet[8*l +: 4] == 4'h0, "R3 pad nibble",
                  64'(out_octet[8*l +: 4]), 64'd0);
        end
        mon_o = o + 1;
      end else if (mon_o > 0 && mon_o < 8) begin
        chk(1'b0, "R4 frame cut short", 64'(mon_o), 64'd8);
        mon_o = 0;
      end
      if (in_valid && !in_ready) chk(1'b0, "R8 ready dropped", 64'd0, 64'd1);
      pend = in_valid && in_ready && (acc_n == 19);
      if (in_valid && in_ready) acc_n = (acc_n == 19) ? 0 : acc_n + 1;
    end
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && !out_sof && in_ready, "R9 reset state",
        {61'd0, out_valid, out_sof, in_ready}, 64'd1);

    // table walk: back-to-back and gapped frames (R1 R2 R3 R4 R8)
    @(posedge clk); #1;
    for (int v = 0; v < NV; v++) begin
      prep(VEC[v][27:16], VEC[v][15:4]);
      send_range(0, 19, int'(VEC[v][3:0]));
    end
    repeat (12) @(posedge clk); #1;

    // R7: long pause before the last sample
    prep(12'h3C3, 12'h0F1);
    send_range(0, 18, 0);
    seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R7 no output before 20th sample", 64'(seen), 64'd0);
    @(posedge clk); #1;
    send_range(19, 19, 0);
    repeat (12) @(posedge clk); #1;

    // R9: reset drops a partial frame
    for (int j = 0; j < 7; j++) drive_one(12'hE00 + 12'(j));
    rst = 1'b1;
    repeat (2) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 after mid-frame reset",
        {62'd0, out_valid, in_ready}, 64'd1);
    @(posedge clk); #1;
    prep(12'h071, 12'h203);
    send_range(0, 19, 0);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(mon_f == nf, "R1 frame count", 64'(mon_f), 64'(nf));
    chk(mon_o == 8, "R4 last frame length", 64'(mon_o), 64'd8);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule